// File: doc/BRIEF.md
# Misaligned load/store request splitter

This block takes one memory access request, given as a byte address, a byte count and a tag, and breaks it into at most two sub-requests that each fall inside one 16-byte granule. Each sub-request carries a granule index and a 16-bit byte-enable map. The first sub-request always names the granule that holds the first byte. The second names the following granule and appears only when the access runs past the end of the first granule.

The byte map comes from a unary mask with as many ones as the access has bytes. That mask is shifted left by the byte offset inside the granule. The low half of the shifted map feeds the first sub-request and the high half feeds the second. No range comparators are needed.

Both sub-requests share the request tag. Each carries a fixed half bit, so that later conflict logic can tell two halves of one request apart. Requests enter and sub-requests leave through registered valid/ready handshakes.

Top module: `ldst_split`

## Requirements
- R1: After reset, both sub-request valids and the error flag are low, and req_ready is high.
- R2: The first sub-request index is address bits [ADDR_W-1:4]. The second sub-request index is that value plus one, wrapping modulo 2^(ADDR_W-4).
- R3: For a length L from 1 to 8 and byte offset o = address bits [3:0], the map is ((1<<L)-1)<<o, 32 bits wide. Bits [15:0] become sub0_be and bits [31:16] become sub1_be. Each sub-request is valid exactly when its enable half is non-zero. Two examples: address 0b1011011 with L=8 gives index 0b101 with enables 0xF800, plus index 0b110 with enables 0x0007. Address 0b1100010 with L=2 gives index 0b110 with enables 0x000C and no second sub-request.
- R4: A request of length 0 is accepted, produces no sub-request and raises no error.
- R5: A request of length 9 to 15 is accepted and produces no sub-request. The error flag is high for exactly the cycle after acceptance.
- R6: req_ready is high exactly when each output channel is either not valid or has its ready high.
- R7: A valid sub-request that is not taken keeps its index, enables and tag unchanged. A sub-request that is taken, with no new request accepted in that cycle, is invalid in the next cycle.
- R8: Both sub-requests carry the tag of the request they came from. sub0_half is 0 and sub1_half is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count, 0 to 15 |
| req_tag | input | TAG_W | Request tag |
| err | output | 1 | Pulse for a rejected length |
| sub0_valid | output | 1 | First sub-request present |
| sub0_ready | input | 1 | Consumer takes the first sub-request |
| sub0_idx | output | ADDR_W-4 | Granule index of the first sub-request |
| sub0_be | output | 16 | Byte enables of the first sub-request |
| sub0_tag | output | TAG_W | Tag of the first sub-request |
| sub0_half | output | 1 | Half bit of the first sub-request, always 0 |
| sub1_valid | output | 1 | Second sub-request present |
| sub1_ready | input | 1 | Consumer takes the second sub-request |
| sub1_idx | output | ADDR_W-4 | Granule index of the second sub-request |
| sub1_be | output | 16 | Byte enables of the second sub-request |
| sub1_tag | output | TAG_W | Tag of the second sub-request |
| sub1_half | output | 1 | Half bit of the second sub-request, always 1 |

## Verification
The hardest case to reach is a partly drained output register. In that case the first sub-request has been taken and the second has not, so a new request waiting at the input must be held off. The bench creates this case with an access that crosses a granule boundary while sub1_ready is held low. It then checks that req_ready stays low, that the second half holds its values, and that the waiting request is taken only once sub1_ready rises. Every address and length of the default 8-bit configuration is also swept, including the wrap of the top granule index to zero.

// File: rtl/ldst_split.sv
module ldst_split #(
  parameter int ADDR_W  = 8,
  parameter int LSB_W   = 4,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int TAG_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [TAG_W-1:0]        req_tag,
  output logic                    err,
  output logic                    sub0_valid,
  input  logic                    sub0_ready,
  output logic [ADDR_W-LSB_W-1:0] sub0_idx,
  output logic [(1<<LSB_W)-1:0]   sub0_be,
  output logic [TAG_W-1:0]        sub0_tag,
  output logic                    sub0_half,
  output logic                    sub1_valid,
  input  logic                    sub1_ready,
  output logic [ADDR_W-LSB_W-1:0] sub1_idx,
  output logic [(1<<LSB_W)-1:0]   sub1_be,
  output logic [TAG_W-1:0]        sub1_tag,
  output logic                    sub1_half
);
  localparam int GB = 1 << LSB_W;
  localparam int IW = ADDR_W - LSB_W;

  logic [2*GB-1:0] ones, bmap;
  logic [IW-1:0]   idx;
  logic            len_bad, take;

  assign ones      = ~({(2*GB){1'b1}} << req_len);
  assign bmap      = ones << req_addr[LSB_W-1:0];
  assign idx       = req_addr[ADDR_W-1:LSB_W];
  assign len_bad   = req_len > LEN_W'(MAX_LEN);
  assign req_ready = (!sub0_valid || sub0_ready) && (!sub1_valid || sub1_ready);
  assign take      = req_valid && req_ready;
  assign sub0_half = 1'b0;
  assign sub1_half = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err        <= 1'b0;
      sub0_valid <= 1'b0;
      sub1_valid <= 1'b0;
      sub0_idx   <= '0;
      sub1_idx   <= '0;
      sub0_be    <= '0;
      sub1_be    <= '0;
      sub0_tag   <= '0;
      sub1_tag   <= '0;
    end else begin
      err <= take && len_bad;
      if (take) begin
        sub0_valid <= !len_bad && (|bmap[GB-1:0]);
        sub1_valid <= !len_bad && (|bmap[2*GB-1:GB]);
        sub0_idx   <= idx;
        sub1_idx   <= idx + 1'b1;
        sub0_be    <= bmap[GB-1:0];
        sub1_be    <= bmap[2*GB-1:GB];
        sub0_tag   <= req_tag;
        sub1_tag   <= req_tag;
      end else begin
        if (sub0_ready) sub0_valid <= 1'b0;
        if (sub1_ready) sub1_valid <= 1'b0;
      end
    end
  end

  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (sub1_valid && !sub1_ready) |-> !req_ready);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sub0_valid && !sub0_ready) |=> (sub0_valid && $stable(sub0_idx) && $stable(sub0_be) && $stable(sub0_tag)));

  a_r2_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (sub0_valid && sub1_valid) |-> (sub1_idx == sub0_idx + 1'b1));

  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (sub0_valid && sub1_valid) |-> (sub0_be[GB-1] && sub1_be[0]));

  a_r3_max_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    sub0_valid |-> ($countones(sub0_be) <= MAX_LEN));

  a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_bad) |=> (err && !sub0_valid && !sub1_valid));

  a_r8_same_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (sub0_valid && sub1_valid) |-> (sub0_tag == sub1_tag));
endmodule

// File: tb/test_ldst_split.sv
module test_ldst_split;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int IW = AW - 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_len = '0;
  logic [2:0] req_tag = '0;
  logic err, sub0_valid, sub1_valid, sub0_half, sub1_half;
  logic sub0_ready = 1'b1, sub1_ready = 1'b1;
  logic [IW-1:0] sub0_idx, sub1_idx;
  logic [15:0] sub0_be, sub1_be;
  logic [2:0] sub0_tag, sub1_tag;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ldst_split i_ldst_split (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag), .err(err),
    .sub0_valid(sub0_valid), .sub0_ready(sub0_ready), .sub0_idx(sub0_idx),
    .sub0_be(sub0_be), .sub0_tag(sub0_tag), .sub0_half(sub0_half),
    .sub1_valid(sub1_valid), .sub1_ready(sub1_ready), .sub1_idx(sub1_idx),
    .sub1_be(sub1_be), .sub1_tag(sub1_tag), .sub1_half(sub1_half)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [3:0] l, input logic [2:0] t);
    req_addr = a; req_len = l; req_tag = t; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_result(input logic [AW-1:0] a, input logic [3:0] l, input logic [2:0] t);
    logic [31:0] m;
    logic [IW-1:0] i0;
    m = (l >= 1 && l <= 8) ? (((32'd1 << l) - 1) << a[3:0]) : 32'd0;
    i0 = a[AW-1:4];
    chk("R3", {sub0_valid, sub1_valid}, {m[15:0] != 0, m[31:16] != 0});
    if (sub0_valid) chk("R3", sub0_be, m[15:0]);
    if (sub1_valid) chk("R3", sub1_be, m[31:16]);
    if (sub0_valid) chk("R2", sub0_idx, i0);
    if (sub1_valid) chk("R2", sub1_idx, IW'(i0 + 1));
    if (sub0_valid) chk("R8", sub0_tag, t);
    if (sub1_valid) chk("R8", sub1_tag, t);
    if (l > 8) chk("R5", err, 1'b1);
    else if (l == 0) chk("R4", {err, sub0_valid, sub1_valid}, 3'b000);
    else chk("R5", err, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {sub0_valid, sub1_valid, err, req_ready}, 4'b0001);
    chk("R8", {sub0_half, sub1_half}, 2'b01);

    send(8'b1011011, 4'd8, 3'd5);
    chk("R3", {sub0_valid, sub0_idx, sub0_be, sub1_valid, sub1_idx, sub1_be},
        {1'b1, 4'b0101, 16'hF800, 1'b1, 4'b0110, 16'h0007});
    send(8'b1100010, 4'd2, 3'd2);
    chk("R3", {sub0_valid, sub0_idx, sub0_be, sub1_valid},
        {1'b1, 4'b0110, 16'h000C, 1'b0});
    @(negedge clk);
    chk("R7", {sub0_valid, sub1_valid}, 2'b00);

    send(8'hF0, 4'd12, 3'd1);
    chk("R5", {err, sub0_valid, sub1_valid}, 3'b100);
    @(negedge clk);
    chk("R5", err, 1'b0);

    for (int a = 0; a < (1 << AW); a++) begin
      for (int l = 0; l < 16; l++) begin
        send(AW'(a), 4'(l), 3'(a + l));
        expect_result(AW'(a), 4'(l), 3'(a + l));
      end
    end
    @(negedge clk);

    sub1_ready = 1'b0;
    send(8'h3C, 4'd8, 3'd6);
    chk("R6", req_ready, 1'b0);
    req_addr = 8'h41; req_len = 4'd4; req_tag = 3'd3; req_valid = 1'b1;
    @(negedge clk);
    chk("R7", {sub0_valid, sub1_valid, sub1_idx, sub1_be, sub1_tag},
        {1'b0, 1'b1, 4'h4, 16'h000F, 3'd6});
    chk("R6", req_ready, 1'b0);
    @(negedge clk);
    chk("R7", {sub1_valid, sub1_idx, sub1_be}, {1'b1, 4'h4, 16'h000F});
    sub1_ready = 1'b1;
    #1;
    chk("R6", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6", {sub0_valid, sub0_idx, sub0_be, sub0_tag, sub1_valid},
        {1'b1, 4'h4, 16'h001E, 3'd3, 1'b0});
    sub0_ready = 1'b0;
    #1;
    chk("R6", req_ready, 1'b0);
    @(negedge clk);
    chk("R7", {sub0_valid, sub0_be}, {1'b1, 16'h001E});
    sub0_ready = 1'b1;
    @(negedge clk);
    chk("R7", {sub0_valid, sub1_valid}, 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule